// File: doc/BRIEF.md
# Synchronous Serial Master Transmitter

This block sends 8-bit characters over a two-wire synchronous link. It drives the bit clock itself and shares one data pin that works in one direction at a time. A host writes a character into a holding register. When the internal shift register is free, the character moves into it and is sent least significant bit first. Each data bit gets one generated clock pulse. No start or stop bits are added, and the clock stays at its idle level between characters.

A divisor input sets the bit period. Each bit lasts 2×(divisor+1) system clocks. The clock spends the first half at its active level and the second half at its idle level. Data changes only on the leading edge, which is the idle-to-active transition, so it is stable at the trailing edge where a receiver samples it. The idle level of the clock can be set high or low. The transmitted data can optionally be inverted.

The holding register and the shift register form a double buffer. A character written while another is being shifted waits in the holding register. It starts the moment the last bit of the previous character ends. A direction input turns the data driver off for receive and keeps new characters from starting.

Top module: `sync_tx_master`

## Requirements
- R1: After reset, holdEmpty=1, shiftIdle=1, sclkOut equals clkIdleHigh and dataOut equals dataInvert.
- R2: A character is sent as exactly 8 clock pulses carrying wrData[0] first through wrData[7] last, with no framing bits. The clock then returns to idle.
- R3: During a transfer, dataOut changes only in the cycle in which sclkOut makes its idle-to-active (leading) transition.
- R4: sclkOut idles at the level of clkIdleHigh: high when it is 1, low when it is 0. The active level is the opposite one.
- R5: Each bit lasts 2×(divisor+1) cycles. The clock is at its active level for the first divisor+1 cycles and at its idle level for the rest.
- R6: With the shift register free, a write sampled at clock edge k loads the shift register at edge k+1. From that cycle on, holdEmpty=1, shiftIdle=0 and the first bit's active half is on the pins.
- R7: A character written while another is shifting stays in the holding register (holdEmpty=0). Its first bit begins in the cycle right after the previous character's last idle half, with no gap.
- R8: A write while the holding register is full is ignored. The held character is the one that is sent.
- R9: With dataInvert=1, every transmitted bit is inverted on dataOut. With dataInvert=0, dataOut carries the bit unchanged.
- R10: sclkOe equals enable and dataOe equals enable AND txMode. With txMode=0 (receive direction) or enable=0, no character starts and the holding register keeps its content.
- R11: shiftIdle returns to 1 in the cycle after the last bit's idle half ends, when no character is waiting. dataOut then returns to dataInvert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| txMode | input | 1 | 1 = transmit direction, 0 = receive direction |
| clkIdleHigh | input | 1 | Idle level of the bit clock |
| dataInvert | input | 1 | Invert transmitted data when 1 |
| divisor | input | 8 | Half-bit length minus one, in system clocks |
| wrStrobe | input | 1 | Host write into the holding register |
| wrData | input | 8 | Character to send |
| holdEmpty | output | 1 | Holding register can accept a character |
| shiftIdle | output | 1 | Shift register holds no bits |
| sclkOut | output | 1 | Bit clock |
| sclkOe | output | 1 | Bit clock driver enable |
| dataOut | output | 1 | Serial data |
| dataOe | output | 1 | Data driver enable |

## Verification
The hardest case to reach is the hand-over between two characters. A second character has to be parked while the first is still shifting, and a third write must arrive while the holding register is full. The bench writes the second character a few cycles after the first one loads and then tries a third write. It then compares every cycle of both characters against a computed waveform, which shows both the gap-free hand-over and that the third write was dropped. Receive direction is reached by writing with txMode low and checking that the character stays parked until transmit is selected again.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  typedef struct packed {
    logic load;   // move holding register into shift register
    logic shift;  // advance to the next bit
  } txStrobe_t;
endpackage

// File: rtl/sync_tx_ctrl.sv
module sync_tx_ctrl
  import sync_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic [DIV_W-1:0] divisor,
  input  logic             holdFull,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             clkActive
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             phase;   // 0 = active half, 1 = idle half
  logic             halfEnd, bitEnd, lastBit;

  always_comb begin
    halfEnd      = busy && (divCnt == divisor);
    bitEnd       = halfEnd && phase;
    lastBit      = (bitCnt == LAST_BIT);
    strobe.load  = active && holdFull && (!busy || (bitEnd && lastBit));
    strobe.shift = active && bitEnd && !lastBit;
    clkActive    = busy && !phase;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (halfEnd) begin
        divCnt <= '0;
        phase  <= ~phase;
        if (bitEnd) begin
          if (lastBit) busy <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_tx_datapath.sv
module sync_tx_datapath
  import sync_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              txBit
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (strobe.load) begin
        shiftReg <= holdReg;
        holdFull <= 1'b0;
      end else if (strobe.shift) begin
        shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      end
      if (wrStrobe && !holdFull) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end
    end
  end

  assign txBit = shiftReg[0];
endmodule

// File: rtl/sync_tx_master.sv
module sync_tx_master
  import sync_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              txMode,
  input  logic              clkIdleHigh,
  input  logic              dataInvert,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              holdEmpty,
  output logic              shiftIdle,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              dataOut,
  output logic              dataOe
);
  txStrobe_t strobe;
  logic holdFull, busy, clkActive, txBit, active;

  assign active = enable && txMode;

  sync_tx_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) ctrl (
    .clk(clk), .rstN(rstN), .active(active), .divisor(divisor),
    .holdFull(holdFull), .strobe(strobe), .busy(busy), .clkActive(clkActive)
  );

  sync_tx_datapath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .strobe(strobe), .holdFull(holdFull), .txBit(txBit)
  );

  assign holdEmpty = !holdFull;
  assign shiftIdle = !busy;
  assign sclkOut   = clkActive ^ clkIdleHigh;
  assign sclkOe    = enable;
  assign dataOe    = active;
  assign dataOut   = (busy && txBit) ^ dataInvert;
endmodule

// File: rtl/sync_tx_master_chk.sv
module sync_tx_master_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic txMode,
  input logic clkIdleHigh,
  input logic dataInvert,
  input logic holdEmpty,
  input logic shiftIdle,
  input logic sclkOut,
  input logic sclkOe,
  input logic dataOut,
  input logic dataOe
);
  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    shiftIdle |-> sclkOut == clkIdleHigh); // R4

  AST_DATA_AT_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftIdle && $past(!shiftIdle) && $stable(dataInvert) && $stable(clkIdleHigh)
     && !$stable(dataOut)) |-> (sclkOut != clkIdleHigh && $past(sclkOut) == clkIdleHigh)); // R3

  AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftIdle) |-> holdEmpty); // R6

  AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !txMode |-> !dataOe); // R10

  AST_RX_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!txMode && shiftIdle) |=> shiftIdle); // R10

  AST_CLK_OE: assert property (@(posedge clk) disable iff (!rstN)
    sclkOe == enable); // R10
endmodule

bind sync_tx_master sync_tx_master_chk chk (.*);

// File: tb/sync_tx_master_test.sv
module sync_tx_master_test;
  logic clk = 0, rstN = 0, enable = 0, txMode = 1, clkIdleHigh = 0, dataInvert = 0;
  logic [7:0] divisor = 0, wrData = 0;
  logic wrStrobe = 0;
  logic holdEmpty, shiftIdle, sclkOut, sclkOe, dataOut, dataOe;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  sync_tx_master uut (.*);

  // vector: {data[17:10], divisor[9:2], clkIdleHigh[1], dataInvert[0]}
  localparam logic [17:0] VECS [5] = '{
    {8'hA5, 8'd0, 1'b0, 1'b0},
    {8'h3C, 8'd1, 1'b1, 1'b0},
    {8'h81, 8'd2, 1'b0, 1'b1},
    {8'hFF, 8'd0, 1'b1, 1'b1},
    {8'h00, 8'd3, 1'b0, 1'b0}
  };

  initial begin
    #400000;
    nFails++; nChecks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeChar(input logic [7:0] d);
    @(negedge clk); wrData = d; wrStrobe = 1;
    @(posedge clk); @(negedge clk); wrStrobe = 0;
  endtask

  // Compare per-cycle waveform of nChar characters sent back to back.
  // Called in the cycle right after the write edge (r=0); r=1 is the load cycle.
  task automatic checkStream(input string req, input int nChar, input logic [7:0] d0,
                             input logic [7:0] d1, input int div, input logic idleHi,
                             input logic inv, input int hold2At);
    int n = div + 1;
    int total = nChar * 16 * n;
    int bad = 0;
    logic [7:0] d;
    logic expClk, expDat, expIdle, expEmpty;
    for (int r = 1; r <= total + 1; r++) begin
      @(negedge clk);
      if (r == hold2At) begin wrData = d1; wrStrobe = 1; end
      if (r == hold2At + 1) begin wrStrobe = 0; end
      if (r == hold2At + 2) begin wrData = 8'hEE; wrStrobe = 1; end
      if (r == hold2At + 3) begin wrStrobe = 0; end
      if (r <= total) begin
        int k = (r - 1) / (16 * n);
        int b = ((r - 1) % (16 * n)) / (2 * n);
        logic ph = (((r - 1) % (2 * n)) >= n);
        d = (k == 0) ? d0 : d1;
        expClk = (!ph) ^ idleHi;
        expDat = d[b] ^ inv;
        expIdle = 0;
      end else begin
        expClk = idleHi; expDat = inv; expIdle = 1;
      end
      if (sclkOut !== expClk || dataOut !== expDat || shiftIdle !== expIdle) begin
        if (bad == 0)
          $display("FAIL %s: cycle %0d clk/dat/idle actual %b%b%b expected %b%b%b",
                   req, r, sclkOut, dataOut, shiftIdle, expClk, expDat, expIdle);
        bad++;
      end
      if (nChar == 2 && r == hold2At + 4) check("R7 held", holdEmpty, 0);
      if (nChar == 2 && r == 16 * n + 1) check("R7 handover frees hold", holdEmpty, 1);
    end
    nChecks++;
    if (bad != 0) nFails++;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 holdEmpty", holdEmpty, 1);
    check("R1 shiftIdle", shiftIdle, 1);
    check("R1 sclk idle", sclkOut, 0);
    check("R1 data idle", dataOut, 0);
    rstN = 1; enable = 1;
    @(negedge clk);
    check("R10 sclkOe", sclkOe, 1);
    check("R10 dataOe", dataOe, 1);

    // Table walk: R2 R4 R5 R9 R11, with R6 at load
    foreach (VECS[i]) begin
      divisor = VECS[i][9:2]; clkIdleHigh = VECS[i][1]; dataInvert = VECS[i][0];
      @(negedge clk);
      check("R4 idle level", sclkOut, VECS[i][1]);
      writeChar(VECS[i][17:10]);
      check("R6 write fills hold", holdEmpty, 0);
      check("R6 not yet loaded", shiftIdle, 1);
      checkStream("R2 R5 R9 R11 waveform", 1, VECS[i][17:10], 8'h00,
                  VECS[i][9:2], VECS[i][1], VECS[i][0], -10);
      check("R6 hold empty after", holdEmpty, 1);
    end

    // R7 + R8: second char during first, third write dropped
    divisor = 1; clkIdleHigh = 0; dataInvert = 0;
    writeChar(8'h96);
    checkStream("R7 R8 back-to-back", 2, 8'h96, 8'h5A, 1, 0, 0, 3);

    // R10: receive direction blocks start and disables data driver
    txMode = 0;
    writeChar(8'hC3);
    for (int j = 0; j < 6; j++) @(negedge clk);
    check("R10 dataOe off in receive", dataOe, 0);
    check("R10 no start in receive", shiftIdle, 1);
    check("R10 hold kept", holdEmpty, 0);
    check("R10 clock idle in receive", sclkOut, 0);
    txMode = 1;
    @(negedge clk);
    check("R10 starts after transmit selected", shiftIdle, 0);
    check("R2 first bit of held char", dataOut, 1);
    enable = 0;
    @(negedge clk);
    check("R10 sclkOe off when disabled", sclkOe, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule